// File: doc/BRIEF.md
# CRC-16 Residue Checker with Register Interface

This block checks a data group for errors with a 16-bit cyclic redundancy code. A host writes the group's data bytes to a data register, then the group's 16-bit check word as two more bytes, high byte first. Each written byte is folded into a 16-bit residue register in a single clock. When the residue is all zeros, the group arrived intact. A dedicated output pin and a bit in a readable status register both report this.

The residue is cleared through a level-held bit in a control register. The host sets this bit and must later write it back to 0 itself. While the bit is 1, the residue stays at zero and data writes are dropped. An error-free group always leaves the residue at zero, so groups can follow one another without re-initialising. There is no limit on the number of bytes. Writes may arrive in bursts separated by any number of idle cycles.

All registers share one address bus, which selects both the written register and the value placed on the read-data output.

Top module: `crc16_residue_chk`

## Requirements
- R1: After reset, the residue is zero, `crc_ok` is 1, and the control bit is 0.
- R2: A write to address 6 folds `wdata` into the residue, most significant bit first. The generator is x^16 + x^12 + x^5 + 1 (0x1021), with no reflection and no final inversion. The new value shows on `crc_ok` after the clock edge that takes the write.
- R3: `crc_ok` is 1 exactly when all 16 residue bits are zero. A group followed by its check word, written high byte first, ends with `crc_ok` at 1.
- R4: When `addr` is 1, `rdata` bit 1 equals `crc_ok` and all other bits of `rdata` are 0.
- R5: A write to address 2 stores `wdata` bit 7 as the control bit. That bit holds its value until the next write to address 2, and reads back on `rdata` bit 7 when `addr` is 2. While the bit is 1, the residue is forced to zero on every clock.
- R6: Data writes made while the control bit is 1 are dropped. Once the bit is cleared, the residue continues from zero.
- R7: Consecutive error-free groups pass without re-initialising, including when idle cycles fall between their bytes.
- R8: Writes to addresses other than 6 and 2 leave the residue unchanged.
- R9: A group whose data or check word is corrupted ends with `crc_ok` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register selected by `addr` |
| crc_ok | output | 1 | High when the residue is all zeros |

## Verification
A wrong residue bit shows up at the ports only through `crc_ok`, and only as a zero/non-zero distinction. A bad update step therefore tends to appear as a missing pass at the end of a group, not as an immediate mismatch. The reference model compares `crc_ok` on every clock, starting one edge after each write. It uses groups whose expected check values are known, so a wrong polynomial, bit order or byte order fails at the group's last byte. A fault in the control bit shows within a cycle, either in the readback at address 2 or as `crc_ok` failing to stay high while data is being dropped.

// File: rtl/crc16_residue_chk.sv
module crc16_residue_chk #(
  parameter int ADDR_W    = 4,
  parameter int BYTE_W    = 8,
  parameter int CRC_W     = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter int DATA_ADDR = 6,
  parameter int STAT_ADDR = 1,
  parameter int CTRL_ADDR = 2,
  parameter int INIT_BIT  = 7,
  parameter int PASS_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              crc_ok
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

  logic [CRC_W-1:0] crc_q;
  logic             init_q;

  function automatic logic [CRC_W-1:0] fold(input logic [CRC_W-1:0] c_in,
                                            input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = c_in;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return c;
  endfunction

  wire data_wr = wr_en && (addr == A_DATA);
  wire ctrl_wr = wr_en && (addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q  <= '0;
      init_q <= 1'b0;
    end else begin
      if (init_q)       crc_q <= '0;
      else if (data_wr) crc_q <= fold(crc_q, wdata);
      if (ctrl_wr)      init_q <= wdata[INIT_BIT];
    end
  end

  assign crc_ok = (crc_q == '0);

  always_comb begin
    rdata = '0;
    if (addr == A_STAT)      rdata[PASS_BIT] = crc_ok;
    else if (addr == A_CTRL) rdata[INIT_BIT] = init_q;
  end
endmodule

// File: rtl/crc16_residue_chk_sva.sv
module crc16_residue_chk_sva #(
  parameter int ADDR_W    = 4,
  parameter int BYTE_W    = 8,
  parameter int CRC_W     = 16,
  parameter int DATA_ADDR = 6,
  parameter int STAT_ADDR = 1,
  parameter int CTRL_ADDR = 2,
  parameter int INIT_BIT  = 7,
  parameter int PASS_BIT  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [BYTE_W-1:0] wdata,
  input logic [BYTE_W-1:0] rdata,
  input logic              crc_ok,
  input logic [CRC_W-1:0]  crc_q,
  input logic              init_q
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

  p_init_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |=> crc_ok);

  p_ctrl_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_CTRL) |=> $stable(init_q));

  p_ctrl_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTRL) |=> init_q == $past(wdata[INIT_BIT]));

  p_drop_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q && wr_en && addr == A_DATA) |=> crc_ok);

  p_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_STAT) |-> (rdata[PASS_BIT] == crc_ok &&
                          $countones(rdata) == int'(crc_ok)));

  p_other_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_q && !(wr_en && addr == A_DATA)) |=> $stable(crc_q));
endmodule

bind crc16_residue_chk crc16_residue_chk_sva #(
  .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .CRC_W(CRC_W), .DATA_ADDR(DATA_ADDR),
  .STAT_ADDR(STAT_ADDR), .CTRL_ADDR(CTRL_ADDR), .INIT_BIT(INIT_BIT),
  .PASS_BIT(PASS_BIT)
) u_sva (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .crc_ok(crc_ok), .crc_q(crc_q), .init_q(init_q)
);

// File: tb/test_crc16_residue_chk.sv
module test_crc16_residue_chk;
  localparam int P = 10;

  logic       clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic       crc_ok;
  int checks = 0, fails = 0;
  logic [15:0] m_crc = 0;
  logic        m_init = 0;
  bit          done = 0;

  crc16_residue_chk i_crc16_residue_chk (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .crc_ok(crc_ok));

  always #(P/2) clk = ~clk;

  function automatic logic [15:0] ref_fold(logic [15:0] c, logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      if (c[15] != d[i]) c = (c << 1) ^ 16'h1021;
      else c = c << 1;
    end
    return c;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, updated with the design's clock edge
  always @(posedge clk) begin
    if (!rst_n) begin m_crc = 0; m_init = 0; end
    else begin
      if (m_init) m_crc = 0;
      else if (wr_en && addr == 6) m_crc = ref_fold(m_crc, wdata);
      if (wr_en && addr == 2) m_init = wdata[7];
    end
  end

  // per-cycle comparison (R3)
  always @(posedge clk) begin
    #(P/4);
    if (rst_n && !done) chk("R3 per-cycle crc_ok", crc_ok, m_crc == 0);
  end

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [3:0] a, string req, logic [7:0] exp);
    @(negedge clk); addr = a; #1; chk(req, rdata, exp);
  endtask

  task automatic send_group(logic [7:0] b[], bit gaps);
    logic [15:0] c = 0;
    foreach (b[i]) begin
      c = ref_fold(c, b[i]);
      wr(6, b[i]);
      if (gaps) idle(i % 3);
    end
    wr(6, c[15:8]);
    if (gaps) idle(2);
    wr(6, c[7:0]);
  endtask

  initial begin
    #(P * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] g2[] = '{8'hA5, 8'h5A, 8'h00, 8'hFF, 8'h3C};
    logic [7:0] g3[] = '{8'h10, 8'h20, 8'h30, 8'h40};
    string s = "123456789";
    idle(3); rst_n = 1; idle(1);
    chk("R1 crc_ok after reset", crc_ok, 1);
    rd(1, "R1/R4 status after reset", 8'h02);
    rd(2, "R1 control bit after reset", 8'h00);

    for (int i = 0; i < 9; i++) wr(6, s[i]);
    idle(1);
    chk("R2 residue nonzero mid-group", crc_ok, 0);
    rd(1, "R4 status shows fail", 8'h00);
    wr(6, 8'h31); wr(6, 8'hC3); idle(1);
    chk("R3 known group with check 31C3 passes", crc_ok, 1);
    rd(1, "R4 status shows pass", 8'h02);

    send_group(g2, 1); idle(1);
    chk("R7 second group with gaps passes without init", crc_ok, 1);
    send_group(g3, 0); idle(1);
    chk("R7 third group passes", crc_ok, 1);

    wr(6, 8'h12); wr(6, 8'h34); wr(6, 8'h00); wr(6, 8'h00); idle(1);
    chk("R9 corrupted check word fails", crc_ok, 0);

    wr(2, 8'h80); idle(1);
    chk("R5 init clears residue", crc_ok, 1);
    rd(2, "R5 control readback set", 8'h80);
    idle(4);
    rd(2, "R5 control bit holds", 8'h80);
    wr(6, 8'h77); wr(6, 8'h01); idle(1);
    chk("R6 data dropped while init set", crc_ok, 1);
    wr(2, 8'h7F); idle(1);
    rd(2, "R5 control cleared by bit 7 only", 8'h00);
    chk("R6 residue zero after clear", crc_ok, 1);

    wr(6, 8'h12); idle(1);
    chk("R2 single byte makes residue nonzero", crc_ok, 0);
    wr(3, 8'hFF); wr(0, 8'h55); wr(5, 8'hAA); wr(1, 8'h80); idle(1);
    chk("R8 foreign writes no effect on crc_ok", crc_ok, 0);
    rd(2, "R8 foreign writes leave control bit", 8'h00);
    begin
      logic [15:0] c = ref_fold(16'h0, 8'h12);
      wr(6, c[15:8]); wr(6, c[7:0]); idle(1);
    end
    chk("R8 group completes unchanged after foreign writes", crc_ok, 1);

    wr(6, 8'h31); wr(6, 8'h32); wr(6, 8'h00); wr(6, 8'h00); idle(1);
    chk("R9 wrong data with zero check fails", crc_ok, 0);
    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule